// File: doc/BRIEF.md
# Card Bus Clock Divider

This block derives the clock that drives a memory-card bus from a faster master clock. A programmable divide field N sets the card clock to the master rate over 2·N, with a 50% duty cycle, so the divided clock stays high for N master cycles and then low for N. A field value of zero selects bypass, where the master clock itself is passed to the card. Double-data-rate operation cannot run in bypass: when the double-data-rate flag is set and the field is zero, a divide value of one is applied in its place.

A new divide value takes effect only when the divided clock falls, so the card never sees a shortened high or low phase. The block also assembles the configuration word held next to the divider: the bus-width code, an always-set flow-control bit, the double-data-rate bit and a bus-speed bit for the faster single-data-rate modes. A combinational helper turns a requested card rate in kHz into the divide value that reaches that rate without exceeding it.

Top module: `cardClkDiv`

## Requirements
- R1: While reset is asserted the divided clock is low, the applied divide value is the field maximum (2^DIV_W-1), and the configuration word holds only the flow-control bit and that maximum divide value.
- R2: With an applied divide value N>0, the divided clock is high for exactly N master cycles and then low for exactly N master cycles.
- R3: When the applied divide value is 0 (bypass), cardClk follows the master clock and the internal divided level stays low.
- R4: When ddrEn is 1 and divIn is 0, a divide value of 1 is applied instead; the configuration word never shows the double-data-rate bit together with a divide value of 0.
- R5: While a nonzero divide value is applied, a new divIn value is taken only at the edge where the divided clock falls; in bypass a new value is taken at the next master edge.
- R6: Configuration bits [DIV_W+1:DIV_W] carry the bus-width code, registered from busWidth: 00 one line, 01 four lines, 10 eight lines; the unused input code 11 is stored as 00.
- R7: Configuration bit DIV_W+2 (flow control) is 1 at all times.
- R8: Configuration bit DIV_W+3 is ddrEn registered on the master clock; bits [DIV_W-1:0] show the applied divide value.
- R9: Configuration bit DIV_W+4 (bus speed) is set, one cycle after the input, when speedMode is 3 or greater and clear for speedMode 0, 1 and 2.
- R10: The helper returns the maximum divide value when reqKhz is 0.
- R11: The helper returns 0 (bypass) when reqKhz is at or above MCLK_KHZ and ddrEn is 0; with ddrEn set it never returns 0.
- R12: Otherwise the helper returns ceil(MCLK_KHZ / (2·reqKhz)), saturated at the field maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divIn | input | DIV_W | Requested divide field (0 = bypass) |
| ddrEn | input | 1 | Double-data-rate request |
| busWidth | input | 2 | Bus-width code (00 one, 01 four, 10 eight lines) |
| speedMode | input | MODE_W | Bus timing mode; 3 and above are the fast single-data-rate modes |
| reqKhz | input | RATE_W | Requested card rate in kHz, helper input |
| cardClk | output | 1 | Clock to the card bus |
| clkCfg | output | DIV_W+5 | Configuration word: speed, DDR, flow control, width, applied divide |
| helpDiv | output | DIV_W | Divide value computed from reqKhz |

## Verification
A corrupted phase counter shows within one half period as a high or low phase of the wrong length on cardClk, and a divide value loaded at the wrong moment shows as a runt phase at the very next transition. A stale or wrong applied divide value appears in the low bits of clkCfg on the cycle it is loaded. The bench replays the intended clock schedule from a behavioural model and compares both outputs on every master cycle, so any such fault is caught in the cycle it first reaches a port.

// File: rtl/cardClkDivPkg.sv
package cardClkDivPkg;
  // strobes from the phase control to the clock datapath
  typedef struct packed {
    logic toggle;  // flip the divided level this edge
    logic load;    // take the pending divide value this edge
    logic park;    // bypass is active, hold the divided level low
  } divStrobe_t;
endpackage

// File: rtl/cardClkCtrl.sv
module cardClkCtrl
  import cardClkDivPkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divIn,
  input  logic             ddrEn,
  input  logic [DIV_W-1:0] activeDiv,
  input  logic             clkLevel,
  output divStrobe_t       strobe,
  output logic [DIV_W-1:0] nextDiv
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] phaseCnt;
  logic             atWrap;

  always_comb begin
    // double data rate may not run in bypass
    nextDiv = (ddrEn && (divIn == '0)) ? ONE : divIn;
    strobe.park = (activeDiv == '0);
    atWrap = !strobe.park && (phaseCnt == (activeDiv - ONE));
    strobe.toggle = atWrap;
    // new value only at a falling edge of the divided clock, or any time in bypass
    strobe.load = strobe.park || (atWrap && clkLevel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (strobe.park || atWrap) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + ONE;
    end
  end
endmodule

// File: rtl/cardClkPath.sv
module cardClkPath
  import cardClkDivPkg::*;
#(
  parameter int DIV_W      = 10,
  parameter int MODE_W     = 3,
  parameter int FAST_MODE  = 3,
  localparam int CFG_W     = DIV_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  divStrobe_t        strobe,
  input  logic [DIV_W-1:0]  nextDiv,
  input  logic              ddrEn,
  input  logic [1:0]        busWidth,
  input  logic [MODE_W-1:0] speedMode,
  output logic [DIV_W-1:0]  activeDiv,
  output logic              clkLevel,
  output logic              cardClk,
  output logic [CFG_W-1:0]  clkCfg
);
  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

  logic [1:0] widthReg;
  logic       ddrReg;
  logic       speedReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeDiv <= DIV_MAX;
      clkLevel  <= 1'b0;
    end else begin
      if (strobe.load) activeDiv <= nextDiv;
      if (strobe.park) clkLevel <= 1'b0;
      else if (strobe.toggle) clkLevel <= ~clkLevel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widthReg <= 2'b00;
      ddrReg   <= 1'b0;
      speedReg <= 1'b0;
    end else begin
      widthReg <= (busWidth == 2'b11) ? 2'b00 : busWidth;
      ddrReg   <= ddrEn;
      speedReg <= (speedMode >= MODE_W'(FAST_MODE));
    end
  end

  assign cardClk = (activeDiv == '0) ? clk : clkLevel;
  assign clkCfg  = {speedReg, ddrReg, 1'b1, widthReg, activeDiv};
endmodule

// File: rtl/cardRateHelper.sv
module cardRateHelper #(
  parameter int DIV_W    = 10,
  parameter int RATE_W   = 18,
  parameter int MCLK_KHZ = 200000
) (
  input  logic [RATE_W-1:0] reqKhz,
  input  logic              ddrEn,
  output logic [DIV_W-1:0]  helpDiv
);
  localparam int CALC_W = RATE_W + 3;
  localparam logic [CALC_W-1:0] MCLK_V  = CALC_W'(MCLK_KHZ);
  localparam logic [CALC_W-1:0] MAX_V   = CALC_W'({DIV_W{1'b1}});

  logic [CALC_W-1:0] twiceReq;
  logic [CALC_W-1:0] quot;

  always_comb begin
    twiceReq = {2'b00, reqKhz, 1'b0};
    quot     = '0;
    if (reqKhz == '0) begin
      helpDiv = {DIV_W{1'b1}};
    end else if ((CALC_W'(reqKhz) >= MCLK_V) && !ddrEn) begin
      helpDiv = '0;
    end else begin
      quot    = (MCLK_V + twiceReq - CALC_W'(1)) / twiceReq;
      helpDiv = (quot > MAX_V) ? {DIV_W{1'b1}} : quot[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/cardClkDiv.sv
module cardClkDiv
  import cardClkDivPkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int MODE_W    = 3,
  parameter int FAST_MODE = 3,
  parameter int RATE_W    = 18,
  parameter int MCLK_KHZ  = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divIn,
  input  logic              ddrEn,
  input  logic [1:0]        busWidth,
  input  logic [MODE_W-1:0] speedMode,
  input  logic [RATE_W-1:0] reqKhz,
  output logic              cardClk,
  output logic [DIV_W+4:0]  clkCfg,
  output logic [DIV_W-1:0]  helpDiv
);
  divStrobe_t       strobe;
  logic [DIV_W-1:0] nextDiv;
  logic [DIV_W-1:0] activeDiv;
  logic             clkLevel;

  cardClkCtrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .divIn(divIn), .ddrEn(ddrEn),
    .activeDiv(activeDiv), .clkLevel(clkLevel),
    .strobe(strobe), .nextDiv(nextDiv)
  );

  cardClkPath #(.DIV_W(DIV_W), .MODE_W(MODE_W), .FAST_MODE(FAST_MODE)) uPath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .nextDiv(nextDiv),
    .ddrEn(ddrEn), .busWidth(busWidth), .speedMode(speedMode),
    .activeDiv(activeDiv), .clkLevel(clkLevel),
    .cardClk(cardClk), .clkCfg(clkCfg)
  );

  cardRateHelper #(.DIV_W(DIV_W), .RATE_W(RATE_W), .MCLK_KHZ(MCLK_KHZ)) uHelp (
    .reqKhz(reqKhz), .ddrEn(ddrEn), .helpDiv(helpDiv)
  );
endmodule

// File: rtl/cardClkDivChk.sv
module cardClkDivChk #(
  parameter int DIV_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W+4:0] clkCfg,
  input logic [DIV_W-1:0] activeDiv,
  input logic             clkLevel
);
  logic [DIV_W-1:0] prevDiv;
  logic             prevLevel;
  logic [DIV_W:0]   runReg;
  logic [DIV_W:0]   curRun;

  // cycles the divided level and the divide value have stayed unchanged
  assign curRun = ((clkLevel != prevLevel) || (activeDiv != prevDiv)) ? '0 : runReg + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevDiv   <= {DIV_W{1'b1}};
      prevLevel <= 1'b1;
      runReg    <= '0;
    end else begin
      prevDiv   <= activeDiv;
      prevLevel <= clkLevel;
      runReg    <= curRun;
    end
  end

  assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (activeDiv != '0) |-> (curRun < {1'b0, activeDiv}));

  assert_bypass_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (activeDiv == '0) |-> !clkLevel);

  assert_ddr_no_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clkCfg[DIV_W+3] |-> (clkCfg[DIV_W-1:0] != '0));

  assert_load_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((activeDiv != $past(activeDiv)) && ($past(activeDiv) != '0))
      |-> ($past(clkLevel) && !clkLevel));

  assert_width_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clkCfg[DIV_W+1:DIV_W] != 2'b11);
endmodule

bind cardClkDiv cardClkDivChk #(.DIV_W(DIV_W)) uChk (
  .clk(clk), .rst_n(rst_n), .clkCfg(clkCfg),
  .activeDiv(activeDiv), .clkLevel(clkLevel)
);

// File: tb/tb_cardClkDiv.sv
module tb_cardClkDiv;
  localparam int DIV_W    = 10;
  localparam int MODE_W   = 3;
  localparam int RATE_W   = 18;
  localparam int MCLK_KHZ = 200000;
  localparam int MAXD     = (1 << DIV_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  divIn = '0;
  logic              ddrEn = 1'b0;
  logic [1:0]        busWidth = 2'b00;
  logic [MODE_W-1:0] speedMode = '0;
  logic [RATE_W-1:0] reqKhz = '0;
  logic              cardClk;
  logic [DIV_W+4:0]  clkCfg;
  logic [DIV_W-1:0]  helpDiv;

  cardClkDiv dut (
    .clk(clk), .rst_n(rst_n), .divIn(divIn), .ddrEn(ddrEn),
    .busWidth(busWidth), .speedMode(speedMode), .reqKhz(reqKhz),
    .cardClk(cardClk), .clkCfg(clkCfg), .helpDiv(helpDiv)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    total = 0;
  int    bad = 0;
  string curReq = "R1";
  bit    running = 1'b0;
  bit    finished = 1'b0;

  // behavioural reference: current divide, level, edges spent in this phase
  int mDiv = MAXD, mLevel = 0, mSpent = 0, mWidth = 0, mDdr = 0, mFast = 0;

  task automatic chk(string req, string what, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d t=%0t", req, what, got, exp, $time);
    end
  endtask

  function automatic int helperRef(int req, bit ddr);
    int q;
    if (req == 0) return MAXD;
    if (req >= MCLK_KHZ && !ddr) return 0;
    q = (MCLK_KHZ + 2 * req - 1) / (2 * req);
    return (q > MAXD) ? MAXD : q;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mDiv = MAXD; mLevel = 0; mSpent = 0; mWidth = 0; mDdr = 0; mFast = 0;
    end else begin
      int want;
      want = (ddrEn && divIn == 0) ? 1 : int'(divIn);
      if (mDiv == 0) begin
        mLevel = 0; mSpent = 0; mDiv = want;
      end else begin
        mSpent++;
        if (mSpent == mDiv) begin
          mSpent = 0;
          if (mLevel == 1) mDiv = want;
          mLevel = 1 - mLevel;
        end
      end
      mWidth = (busWidth == 2'b11) ? 0 : int'(busWidth);
      mDdr   = int'(ddrEn);
      mFast  = (int'(speedMode) >= 3) ? 1 : 0;
    end
    if (running) begin
      #5;  // clk is high here
      chk(curReq, "cardClk", longint'(cardClk), (mDiv == 0) ? 1 : mLevel);
      chk(curReq, "clkCfg", longint'(clkCfg),
          (longint'(mFast) << (DIV_W + 4)) | (longint'(mDdr) << (DIV_W + 3)) |
          (longint'(1) << (DIV_W + 2)) | (longint'(mWidth) << DIV_W) | longint'(mDiv));
    end
  end

  task automatic helperCase(int req, bit ddr, string tag);
    @(negedge clk);
    reqKhz = RATE_W'(req);
    ddrEn  = ddr;
    #2;
    chk(tag, "helpDiv", longint'(helpDiv), helperRef(req, ddr));
  endtask

  initial begin
    divIn = DIV_W'(3);
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "reset cardClk", longint'(cardClk), 0);
    chk("R1", "reset clkCfg", longint'(clkCfg), (longint'(1) << (DIV_W + 2)) | MAXD);
    @(negedge clk);
    rst_n   = 1'b1;
    running = 1'b1;
    curReq  = "R2";
    repeat (2200) @(negedge clk);
    // change divide while the divided clock is high and while low
    curReq = "R5";
    divIn = DIV_W'(5);
    repeat (7) @(negedge clk);
    divIn = DIV_W'(1);
    repeat (30) @(negedge clk);
    divIn = DIV_W'(4);
    repeat (30) @(negedge clk);
    curReq = "R3";
    divIn = '0;
    repeat (30) @(negedge clk);
    curReq = "R4";
    ddrEn = 1'b1;
    repeat (30) @(negedge clk);
    curReq = "R8";
    ddrEn = 1'b0;
    divIn = DIV_W'(2);
    repeat (12) @(negedge clk);
    ddrEn = 1'b1;
    repeat (6) @(negedge clk);
    ddrEn = 1'b0;
    curReq = "R6";
    for (int w = 0; w < 4; w++) begin
      busWidth = 2'(w);
      repeat (4) @(negedge clk);
    end
    curReq = "R9";
    for (int s = 0; s < 8; s++) begin
      speedMode = MODE_W'(s);
      repeat (3) @(negedge clk);
    end
    curReq = "R7";
    repeat (10) @(negedge clk);
    helperCase(0, 1'b0, "R10");
    helperCase(0, 1'b1, "R10");
    helperCase(MCLK_KHZ, 1'b0, "R11");
    helperCase(250000, 1'b0, "R11");
    helperCase(MCLK_KHZ, 1'b1, "R11");
    helperCase(250000, 1'b1, "R11");
    helperCase(50000, 1'b0, "R12");
    helperCase(30000, 1'b0, "R12");
    helperCase(100, 1'b0, "R12");
    helperCase(98, 1'b0, "R12");
    helperCase(97, 1'b1, "R12");
    helperCase(1, 1'b0, "R12");
    ddrEn = 1'b0;
    repeat (4) @(negedge clk);
    running  = 1'b0;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL %s watchdog expired got=running exp=done", curReq);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule